// File: doc/BRIEF.md
# Floppy Drive-Side Control Outputs

This block produces the control lines that a floppy disk controller presents to its drives. The host programs a small set of registers through single-cycle write strobes that share one data bus. From those registers the block derives the two data-rate pins, a density indication with selectable polarity, the decoded drive-select lines, the motor-enable lines, a "drive 2 or 3 selected" line, and a power-down and idle indication. The power-down and idle indication can replace drive select 1 and motor 1 on two shared pins.

The data rate can be written through either of two aliased rate registers, the configuration rate register and the rate-select register. The rate in force is always the one most recently written. A two-state machine records which register was written last: `SRC_CCR` after a configuration rate write and `SRC_DSR` after a rate-select write. A write to the rate-select register wins when both strobes arrive in the same cycle. Reset enters `SRC_DSR`, with both registers holding 00.

A second, three-state machine tracks power. It moves to `PWR_DOWN` whenever any of the three power-down request bits is set. Otherwise it moves to `PWR_IDLE` while the command engine reports idle, and to `PWR_ACTIVE` in every other case. The next state is re-evaluated on every clock, so each state can be reached from each other state. The state is registered, so the power outputs follow their cause one clock later. The data separator, the command sequencer and the FIFO are outside this block.

Top module: `fdc_drive_ctrl`

## Requirements
- R1: `rate_o` equals bits 1..0 of the last write to either rate register (`wr_ccr` or `wr_dsr`). Both registers and `rate_o` reset to 00. When both strobes fire together, the rate-select write wins.
- R2: Rate codes are 00 = 500 Kbps, 01 = 300 Kbps, 10 = 250 Kbps and 11 = 1 Mbps. With the polarity bit clear, `dens_o` is 1 for 00 and 11 (high density) and 0 for 01 and 10 (low density).
- R3: Bit 2 of the power configuration register (`wr_pmc`) inverts `dens_o`.
- R4: The drive register (`wr_dor`) holds the selected drive in bits 1..0 and the motor enables for drives 0..3 in bits 4..7. `drv_sel_n[n]` is low only when bits 1..0 equal n and motor bit 4+n is 1. At most one `drv_sel_n` line is low.
- R5: `motor_n[i]` is the inverse of drive register bit 4+i.
- R6: `drv23_n` is low exactly when drive 2 or drive 3 has its select line asserted.
- R7: The power-down request is the OR of rate-select bit 6, function-enable register bit 3 (`wr_fen`) and test register bit 0 (`wr_tst`). One clock after the request becomes true, the power state becomes `PWR_DOWN` and power-down reads 1. A request written to the configuration rate register has no effect.
- R8: The idle indication is 1 one clock after `fdc_idle` is high or the power state is `PWR_DOWN`, and 0 otherwise.
- R9: With power configuration bit 0 set, `share_a` carries power-down and `share_b` carries idle. With that bit clear, `share_a` carries `drv_sel_n[1]` and `share_b` carries `motor_n[1]`.
- R10: Master reset clears the drive, function-enable, test and power configuration registers. After reset all drive-select and motor lines are high, `drv23_n` is 1, `rate_o` is 00 and `dens_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, synchronous |
| wdata | input | 8 | Host write data shared by all strobes |
| wr_dor | input | 1 | Write strobe, drive output register |
| wr_ccr | input | 1 | Write strobe, configuration rate register |
| wr_dsr | input | 1 | Write strobe, rate-select register |
| wr_fen | input | 1 | Write strobe, function-enable register |
| wr_tst | input | 1 | Write strobe, test register |
| wr_pmc | input | 1 | Write strobe, power configuration register |
| fdc_idle | input | 1 | Idle flag from the command engine |
| rate_o | output | 2 | Data-rate pins |
| dens_o | output | 1 | Density select |
| drv_sel_n | output | 4 | Drive selects, active low |
| motor_n | output | 4 | Motor enables, active low |
| drv23_n | output | 1 | Drive 2 or 3 selected, active low |
| share_a | output | 1 | Drive select 1 or power-down |
| share_b | output | 1 | Motor 1 or idle |

## Verification
The hardest situation to observe is power-down itself, because it has no dedicated pin. It only appears on `share_a`, and only after the pin-function bit has been set. The stimulus therefore writes the power configuration register first. It then raises and clears each of the three request sources one at a time and checks that the shared pins follow one clock later. The pin function is switched while a drive select is asserted, so that both meanings of each shared pin are seen. The rate alias is covered by interleaving the two rate registers in a table. A power-down bit written to the configuration rate register is checked to leave the shared pin low.

// File: rtl/fdc_drv_pkg.sv
package fdc_drv_pkg;
    typedef enum logic {
        SRC_CCR,
        SRC_DSR
    } rate_src_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE,
        PWR_IDLE,
        PWR_DOWN
    } pwr_state_e;

    localparam int RATE_W       = 2;
    localparam int DSR_PD_BIT   = 6;
    localparam int FEN_PD_BIT   = 3;
    localparam int TST_PD_BIT   = 0;
    localparam int PMC_SWAP_BIT = 0;
    localparam int PMC_DINV_BIT = 2;

    localparam logic [RATE_W-1:0] RATE_500K = 2'b00;
    localparam logic [RATE_W-1:0] RATE_300K = 2'b01;
    localparam logic [RATE_W-1:0] RATE_250K = 2'b10;
    localparam logic [RATE_W-1:0] RATE_1M   = 2'b11;
endpackage

// File: rtl/fdc_rate_track.sv
module fdc_rate_track
    import fdc_drv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ccr,
    input  logic              wr_dsr,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              pd_in,
    output logic [RATE_W-1:0] rate,
    output logic              dsr_pd
);
    rate_src_e         src_q, src_d;
    logic [RATE_W-1:0] ccr_rate_q;
    logic [RATE_W-1:0] dsr_rate_q;

    // Next source: the rate-select register wins a same-cycle tie.
    always_comb begin
        src_d = src_q;
        if (wr_dsr)      src_d = SRC_DSR;
        else if (wr_ccr) src_d = SRC_CCR;
    end

    always_ff @(posedge clk) begin
        if (rst) src_q <= SRC_DSR;
        else     src_q <= src_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_rate_q <= '0;
            dsr_rate_q <= '0;
            dsr_pd     <= 1'b0;
        end else begin
            if (wr_ccr) ccr_rate_q <= rate_in;
            if (wr_dsr) begin
                dsr_rate_q <= rate_in;
                dsr_pd     <= pd_in;
            end
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_CCR: rate = ccr_rate_q;
            SRC_DSR: rate = dsr_rate_q;
            default: rate = dsr_rate_q;
        endcase
    end

    // R1
    rate_dsr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_dsr |=> rate == $past(rate_in));
    // R1
    rate_ccr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ccr && !wr_dsr) |=> rate == $past(rate_in));
    // R1
    rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_ccr && !wr_dsr) |=> $stable(rate));
endmodule

// File: rtl/fdc_drive_decode.sv
module fdc_drive_decode #(
    parameter int NUM_DRIVES = 4,
    localparam int SEL_W = $clog2(NUM_DRIVES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_dor,
    input  logic [SEL_W-1:0]      sel_in,
    input  logic [NUM_DRIVES-1:0] mot_in,
    output logic [NUM_DRIVES-1:0] drv_sel_n,
    output logic [NUM_DRIVES-1:0] motor_n,
    output logic                  drv23_n
);
    logic [SEL_W-1:0]      sel_q;
    logic [NUM_DRIVES-1:0] mot_q;
    logic [NUM_DRIVES-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            mot_q <= '0;
        end else if (wr_dor) begin
            sel_q <= sel_in;
            mot_q <= mot_in;
        end
    end

    for (genvar n = 0; n < NUM_DRIVES; n++) begin : g_drv
        assign hit[n]       = (sel_q == SEL_W'(n)) && mot_q[n];
        assign drv_sel_n[n] = ~hit[n];
        assign motor_n[n]   = ~mot_q[n];
    end

    always_comb begin
        drv23_n = 1'b1;
        for (int n = 2; n < NUM_DRIVES; n++) begin
            if (hit[n]) drv23_n = 1'b0;
        end
    end

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~drv_sel_n));
    // R4
    sel_needs_motor_chk: assert property (@(posedge clk) disable iff (rst)
        ((~drv_sel_n & motor_n) == '0));
    // R5
    motor_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_dor |=> motor_n == ~$past(mot_in));
    // R10
    reset_lines_chk: assert property (@(posedge clk)
        rst |=> (motor_n == '1 && drv_sel_n == '1 && drv23_n));
endmodule

// File: rtl/fdc_power_fsm.sv
module fdc_power_fsm
    import fdc_drv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_fen,
    input  logic wr_tst,
    input  logic fen_pd_in,
    input  logic tst_pd_in,
    input  logic dsr_pd,
    input  logic fdc_idle,
    output logic pd,
    output logic idle
);
    pwr_state_e state_q, state_d;
    logic       fen_pd_q, tst_pd_q, pd_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            fen_pd_q <= 1'b0;
            tst_pd_q <= 1'b0;
        end else begin
            if (wr_fen) fen_pd_q <= fen_pd_in;
            if (wr_tst) tst_pd_q <= tst_pd_in;
        end
    end

    assign pd_req = dsr_pd | fen_pd_q | tst_pd_q;

    always_comb begin
        unique case (state_q)
            PWR_ACTIVE, PWR_IDLE, PWR_DOWN: begin
                if (pd_req)        state_d = PWR_DOWN;
                else if (fdc_idle) state_d = PWR_IDLE;
                else               state_d = PWR_ACTIVE;
            end
            default: state_d = PWR_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PWR_ACTIVE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PWR_ACTIVE: begin pd = 1'b0; idle = 1'b0; end
            PWR_IDLE:   begin pd = 1'b0; idle = 1'b1; end
            PWR_DOWN:   begin pd = 1'b1; idle = 1'b1; end
            default:    begin pd = 1'b0; idle = 1'b0; end
        endcase
    end

    // R7
    pd_entry_chk: assert property (@(posedge clk) disable iff (rst)
        pd_req |=> pd);
    // R8
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (fdc_idle || pd_req) |=> idle);
    // R8
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!fdc_idle && !pd_req) |=> (!idle && !pd));
endmodule

// File: rtl/fdc_drive_ctrl.sv
module fdc_drive_ctrl
    import fdc_drv_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_DRIVES = 4,
    localparam int SEL_W     = $clog2(NUM_DRIVES),
    localparam int MOT_LSB   = DATA_W - NUM_DRIVES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  wr_dor,
    input  logic                  wr_ccr,
    input  logic                  wr_dsr,
    input  logic                  wr_fen,
    input  logic                  wr_tst,
    input  logic                  wr_pmc,
    input  logic                  fdc_idle,
    output logic [RATE_W-1:0]     rate_o,
    output logic                  dens_o,
    output logic [NUM_DRIVES-1:0] drv_sel_n,
    output logic [NUM_DRIVES-1:0] motor_n,
    output logic                  drv23_n,
    output logic                  share_a,
    output logic                  share_b
);
    logic dsr_pd, pd, idle;
    logic pin_swap_q, dens_inv_q, high_dens;

    fdc_rate_track u_rate (
        .clk     (clk),
        .rst     (rst),
        .wr_ccr  (wr_ccr),
        .wr_dsr  (wr_dsr),
        .rate_in (wdata[RATE_W-1:0]),
        .pd_in   (wdata[DSR_PD_BIT]),
        .rate    (rate_o),
        .dsr_pd  (dsr_pd)
    );

    fdc_drive_decode #(.NUM_DRIVES(NUM_DRIVES)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .wr_dor    (wr_dor),
        .sel_in    (wdata[SEL_W-1:0]),
        .mot_in    (wdata[DATA_W-1:MOT_LSB]),
        .drv_sel_n (drv_sel_n),
        .motor_n   (motor_n),
        .drv23_n   (drv23_n)
    );

    fdc_power_fsm u_pwr (
        .clk       (clk),
        .rst       (rst),
        .wr_fen    (wr_fen),
        .wr_tst    (wr_tst),
        .fen_pd_in (wdata[FEN_PD_BIT]),
        .tst_pd_in (wdata[TST_PD_BIT]),
        .dsr_pd    (dsr_pd),
        .fdc_idle  (fdc_idle),
        .pd        (pd),
        .idle      (idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_swap_q <= 1'b0;
            dens_inv_q <= 1'b0;
        end else if (wr_pmc) begin
            pin_swap_q <= wdata[PMC_SWAP_BIT];
            dens_inv_q <= wdata[PMC_DINV_BIT];
        end
    end

    always_comb begin
        unique case (rate_o)
            RATE_500K, RATE_1M:   high_dens = 1'b1;
            RATE_300K, RATE_250K: high_dens = 1'b0;
            default:              high_dens = 1'b0;
        endcase
    end

    assign dens_o  = high_dens ^ dens_inv_q;
    assign share_a = pin_swap_q ? pd   : drv_sel_n[1];
    assign share_b = pin_swap_q ? idle : motor_n[1];

    // R2
    dens_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!dens_inv_q && (rate_o == RATE_250K || rate_o == RATE_300K)) |-> !dens_o);
    // R9
    share_legacy_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_swap_q |-> (share_a == drv_sel_n[1] && share_b == motor_n[1]));
    // R10
    reset_rate_chk: assert property (@(posedge clk)
        rst |=> (rate_o == RATE_500K && dens_o));
endmodule

// File: tb/sim_fdc_drive_ctrl.sv
module sim_fdc_drive_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] wdata = '0;
    logic       wr_dor = 0, wr_ccr = 0, wr_dsr = 0, wr_fen = 0, wr_tst = 0, wr_pmc = 0;
    logic       fdc_idle = 0;
    logic [1:0] rate_o;
    logic       dens_o, drv23_n, share_a, share_b;
    logic [3:0] drv_sel_n, motor_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    fdc_drive_ctrl u0 (
        .clk(clk), .rst(rst), .wdata(wdata),
        .wr_dor(wr_dor), .wr_ccr(wr_ccr), .wr_dsr(wr_dsr),
        .wr_fen(wr_fen), .wr_tst(wr_tst), .wr_pmc(wr_pmc),
        .fdc_idle(fdc_idle), .rate_o(rate_o), .dens_o(dens_o),
        .drv_sel_n(drv_sel_n), .motor_n(motor_n), .drv23_n(drv23_n),
        .share_a(share_a), .share_b(share_b)
    );

    // {is_dsr, data, expected rate, expected density}
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 8'h01, 2'b01, 1'b0},
        {1'b1, 8'h02, 2'b10, 1'b0},
        {1'b0, 8'h03, 2'b11, 1'b1},
        {1'b1, 8'h00, 2'b00, 1'b1},
        {1'b0, 8'h02, 2'b10, 1'b0},
        {1'b0, 8'h41, 2'b01, 1'b0},
        {1'b1, 8'h03, 2'b11, 1'b1},
        {1'b0, 8'h00, 2'b00, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int which, input logic [7:0] d);
        @(negedge clk);
        wdata = d;
        case (which)
            0: wr_dor = 1;
            1: wr_ccr = 1;
            2: wr_dsr = 1;
            3: wr_fen = 1;
            4: wr_tst = 1;
            default: wr_pmc = 1;
        endcase
        @(negedge clk);
        {wr_dor, wr_ccr, wr_dsr, wr_fen, wr_tst, wr_pmc} = '0;
    endtask

    task automatic chk_dec(input logic [7:0] d, input logic [3:0] es, input logic [3:0] em,
                           input logic e23);
        wr(0, d);
        chk("R4 drv_sel_n", 16'(drv_sel_n), 16'(es));
        chk("R5 motor_n", 16'(motor_n), 16'(em));
        chk("R6 drv23_n", 16'(drv23_n), 16'(e23));
    endtask

    task automatic chk_share(input string req, input logic ea, input logic eb);
        @(negedge clk);
        chk(req, 16'({share_a, share_b}), 16'({ea, eb}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state
        chk("R10 rate/dens", 16'({rate_o, dens_o}), 16'({2'b00, 1'b1}));
        chk("R10 lines", 16'({drv_sel_n, motor_n, drv23_n}), 16'({4'hF, 4'hF, 1'b1}));

        // R1 / R2 table walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][11] ? 2 : 1, VEC[i][10:3]);
            chk("R1 rate", 16'(rate_o), 16'(VEC[i][2:1]));
            chk("R2 dens", 16'(dens_o), 16'(VEC[i][0]));
        end

        // R1 simultaneous write: rate-select wins
        @(negedge clk);
        wdata = 8'h03; wr_ccr = 1; wr_dsr = 1;
        @(negedge clk);
        wr_ccr = 0; wr_dsr = 0;
        chk("R1 tie", 16'(rate_o), 16'h3);

        // R3 polarity invert
        wr(5, 8'h04);
        chk("R3 dens inverted 1M", 16'(dens_o), 16'h0);
        wr(1, 8'h02);
        chk("R3 dens inverted 250K", 16'(dens_o), 16'h1);
        wr(5, 8'h00);
        chk("R3 dens restored", 16'(dens_o), 16'h0);

        // R4 R5 R6 decode
        chk_dec(8'h12, 4'hF, 4'hE, 1'b1);
        chk_dec(8'h42, 4'hB, 4'hB, 1'b0);
        chk_dec(8'h83, 4'h7, 4'h7, 1'b0);
        chk_dec(8'hF1, 4'hD, 4'h0, 1'b1);

        // R9 legacy shared pins (drive 1 selected, motor 1 on)
        chk("R9 legacy", 16'({share_a, share_b}), 16'h0);

        // R9 swapped: power-down and idle
        wr(5, 8'h01);
        chk("R9 swapped", 16'({share_a, share_b}), 16'h0);
        fdc_idle = 1;
        chk_share("R8 idle high", 1'b0, 1'b1);
        fdc_idle = 0;
        chk_share("R8 idle low", 1'b0, 1'b0);
        wr(4, 8'h01);
        chk_share("R7 test pd", 1'b1, 1'b1);
        wr(4, 8'h00);
        chk_share("R7 test pd clear", 1'b0, 1'b0);
        wr(3, 8'h08);
        chk_share("R7 fen pd", 1'b1, 1'b1);
        wr(3, 8'h00);
        chk_share("R7 fen pd clear", 1'b0, 1'b0);
        wr(2, 8'h40);
        chk_share("R7 dsr pd", 1'b1, 1'b1);
        wr(2, 8'h00);
        chk_share("R7 dsr pd clear", 1'b0, 1'b0);
        wr(1, 8'h40);
        chk_share("R7 ccr bit6 no effect", 1'b0, 1'b0);

        // R10 mid-run reset
        wr(1, 8'h01);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R10 rate after reset", 16'({rate_o, dens_o}), 16'({2'b00, 1'b1}));
        chk("R10 lines after reset", 16'({drv_sel_n, motor_n, drv23_n}), 16'({4'hF, 4'hF, 1'b1}));
        chk("R10 pmc cleared", 16'({share_a, share_b}), 16'h3);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule